// File: doc/BRIEF.md
# Serial Port Interrupt Request Generator

This block turns the status flags of a serial communication port into interrupt requests for an interrupt controller. A small writable control register holds three enables: one for the receive data request, one for the receive-with-error request and one for the transmit data request. The receiver and transmitter sides supply the status flags: receive register full, transmit register empty, and three receive error flags (parity, framing, overrun).

Each request is a level. It is formed combinationally from the registered enables and the live status flags, so it drops in the same cycle that software reads the receive register or writes the transmit register. If any error flag is raised and the error enable is set, the receive side signals on the exception line. In that case the normal receive line stays low, so the interrupt controller never sees both at once.

Both a hardware reset and a synchronous software reset clear the enables. Neither reset has any effect on the status flags, which belong to the datapath.

Top module: `sci_irq_gen`

## Requirements
- R1: When `ctl_wr` is high at a rising clock edge and `soft_rst` is low, the enables load from `ctl_wdata`. Bit 0 is the receive enable, bit 1 the receive-error enable and bit 2 the transmit enable. The new values act from the next cycle.
- R2: A high `rst` at a clock edge clears all three enables.
- R3: A high `soft_rst` at a clock edge clears all three enables. It wins over a write in the same cycle.
- R4: `irq_rx` is high when the receive enable and `rx_full` are both high and `irq_rx_exc` is low.
- R5: While the receive enable is clear, `irq_rx` stays low whatever the value of `rx_full`.
- R6: `irq_rx_exc` is high when the receive-error enable is set and at least one of `err_parity`, `err_framing` or `err_overrun` is high. It does not depend on `rx_full`.
- R7: `irq_rx` is low whenever `irq_rx_exc` is high.
- R8: `irq_tx` is high exactly when the transmit enable and `tx_empty` are both high.
- R9: All request outputs follow their status inputs in the same cycle, with no register between them. When a flag falls, its request falls with it.
- R10: While the receive-error enable is clear, the error flags raise no request and do not mask `irq_rx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| soft_rst | input | 1 | Synchronous software reset of the enables, active high |
| ctl_wr | input | 1 | Write strobe for the enable register |
| ctl_wdata | input | 3 | Enable values: [0] receive, [1] receive error, [2] transmit |
| rx_full | input | 1 | Receive data register holds unread data |
| tx_empty | input | 1 | Transmit data register can accept data |
| err_parity | input | 1 | Receive parity error flag |
| err_framing | input | 1 | Receive framing error flag |
| err_overrun | input | 1 | Receive overrun error flag |
| irq_rx | output | 1 | Receive data request |
| irq_rx_exc | output | 1 | Receive data with error request |
| irq_tx | output | 1 | Transmit data request |

## Verification
The bench targets four cases that a faulty design would get wrong:
- A single error flag raised while `rx_full` is high. If priority were missing, both receive lines would rise together.
- Error flags raised while the receive-error enable is clear. If `irq_rx` were masked by the raw error flags, it would wrongly drop.
- A write and a software reset in the same cycle. If write won, the written enables would survive.
- Flags that change every cycle, sampled before the next edge. If a request were registered, it would trail its flag by one cycle.

// File: rtl/sci_irq_pkg.sv
package sci_irq_pkg;

    localparam int EN_W  = 3;
    localparam int ERR_W = 3;

    typedef struct packed {
        logic tx;
        logic rx_exc;
        logic rx;
    } irq_en_t;

    typedef struct packed {
        logic tx;
        logic rx_exc;
        logic rx;
    } irq_req_t;

    localparam irq_en_t EN_CLEAR = '{tx: 1'b0, rx_exc: 1'b0, rx: 1'b0};

    function automatic irq_en_t unpack_en(input logic [EN_W-1:0] raw);
        irq_en_t e;
        e = irq_en_t'(raw);
        return e;
    endfunction

endpackage

// File: rtl/sci_irq_ctl_reg.sv
module sci_irq_ctl_reg
    import sci_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 soft_rst,
    input  logic                 wr,
    input  logic [EN_W-1:0]      wdata,
    output irq_en_t              en
);

    irq_en_t en_q;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            en_q <= EN_CLEAR;
        end else if (wr) begin
            en_q <= unpack_en(wdata);
        end
    end

    assign en = en_q;

    // R3: software reset clears all enables, over any write
    a_r3_soft_clear: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (en == EN_CLEAR));

    // R1: a write lands on the next edge
    a_r1_write_loads: assert property (@(posedge clk) disable iff (rst)
        (wr && !soft_rst) |=> (en == irq_en_t'($past(wdata))));

    // R1: without a write or reset the enables hold
    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr && !soft_rst) |=> $stable(en));

endmodule

// File: rtl/sci_irq_req.sv
module sci_irq_req
    import sci_irq_pkg::*;
#(
    parameter int NERR = ERR_W
) (
    input  irq_en_t              en,
    input  logic                 rx_full,
    input  logic                 tx_empty,
    input  logic [NERR-1:0]      err,
    output irq_req_t             req
);

    localparam int CHAIN_W = NERR + 1;

    logic [CHAIN_W-1:0] err_or;
    assign err_or[0] = 1'b0;

    for (genvar g = 0; g < NERR; g++) begin : g_err_or
        assign err_or[g+1] = err_or[g] | err[g];
    end

    logic exc_req;

    always_comb begin
        exc_req    = en.rx_exc & err_or[NERR];
        req.rx_exc = exc_req;
        req.rx     = en.rx & rx_full & ~exc_req;
        req.tx     = en.tx & tx_empty;
    end

endmodule

// File: rtl/sci_irq_gen.sv
module sci_irq_gen
    import sci_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            soft_rst,
    input  logic            ctl_wr,
    input  logic [2:0]      ctl_wdata,
    input  logic            rx_full,
    input  logic            tx_empty,
    input  logic            err_parity,
    input  logic            err_framing,
    input  logic            err_overrun,
    output logic            irq_rx,
    output logic            irq_rx_exc,
    output logic            irq_tx
);

    irq_en_t          en;
    irq_req_t         req;
    logic [ERR_W-1:0] err_vec;

    assign err_vec = {err_overrun, err_framing, err_parity};

    sci_irq_ctl_reg u_ctl (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .wr       (ctl_wr),
        .wdata    (ctl_wdata),
        .en       (en)
    );

    sci_irq_req #(.NERR(ERR_W)) u_req (
        .en       (en),
        .rx_full  (rx_full),
        .tx_empty (tx_empty),
        .err      (err_vec),
        .req      (req)
    );

    assign irq_rx     = req.rx;
    assign irq_rx_exc = req.rx_exc;
    assign irq_tx     = req.tx;

    // R7: the two receive lines are never raised together
    a_r7_rx_exclusive: assert property (@(posedge clk) disable iff (rst)
        $countones({irq_rx, irq_rx_exc}) <= 1);

    // R5: no receive request while receive enable is clear
    a_r5_rx_gated: assert property (@(posedge clk) disable iff (rst)
        !en.rx |-> !irq_rx);

    // R6: the exception line needs a raised error flag
    a_r6_exc_needs_err: assert property (@(posedge clk) disable iff (rst)
        irq_rx_exc |-> (err_parity || err_framing || err_overrun));

    // R8: the transmit line needs an empty transmit register
    a_r8_tx_needs_empty: assert property (@(posedge clk) disable iff (rst)
        irq_tx |-> tx_empty);

    // R2: the cycle after a hardware reset no request is possible
    a_r2_hw_clear: assert property (@(posedge clk)
        $past(rst) |-> !(irq_rx || irq_rx_exc || irq_tx));

endmodule

// File: tb/sim_sci_irq_gen.sv
module sim_sci_irq_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soft_rst = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [2:0] ctl_wdata = 3'b000;
    logic       rx_full = 1'b0;
    logic       tx_empty = 1'b0;
    logic       err_parity = 1'b0;
    logic       err_framing = 1'b0;
    logic       err_overrun = 1'b0;
    logic       irq_rx, irq_rx_exc, irq_tx;

    int checks = 0;
    int errors = 0;
    logic [2:0] m_en = 3'b000;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sci_irq_gen u0 (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .rx_full(rx_full), .tx_empty(tx_empty),
        .err_parity(err_parity), .err_framing(err_framing),
        .err_overrun(err_overrun),
        .irq_rx(irq_rx), .irq_rx_exc(irq_rx_exc), .irq_tx(irq_tx)
    );

    function automatic logic exp_exc(input logic [2:0] en, input logic e0,
                                     input logic e1, input logic e2);
        return en[1] & (e0 | e1 | e2);
    endfunction

    function automatic logic exp_rx(input logic [2:0] en, input logic full,
                                    input logic exc);
        return en[0] & full & ~exc;
    endfunction

    function automatic logic exp_tx(input logic [2:0] en, input logic empty);
        return en[2] & empty;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b (en=%b)", tag, act, exp, m_en);
        end
    endtask

    task automatic check_all(input string tag);
        logic x;
        x = exp_exc(m_en, err_parity, err_framing, err_overrun);
        chk({tag, " R6/R10 irq_rx_exc"}, irq_rx_exc, x);
        chk({tag, " R4/R5/R7 irq_rx"}, irq_rx, exp_rx(m_en, rx_full, x));
        chk({tag, " R8 irq_tx"}, irq_tx, exp_tx(m_en, tx_empty));
    endtask

    task automatic set_flags(input logic f, input logic t, input logic [2:0] e);
        rx_full = f; tx_empty = t;
        err_parity = e[0]; err_framing = e[1]; err_overrun = e[2];
    endtask

    task automatic write_en(input logic [2:0] v);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(posedge clk);
        m_en = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R2: enables clear after reset, all flags raised
        set_flags(1'b1, 1'b1, 3'b111);
        #1;
        check_all("R2 reset");

        // R1: receive only, then error on a masked exception path (R10)
        write_en(3'b001);
        set_flags(1'b1, 1'b1, 3'b000); #1; check_all("R1 rx only");
        set_flags(1'b1, 1'b1, 3'b010); #1; check_all("R10 err masked");
        chk("R10 irq_rx kept", irq_rx, 1'b1);

        // R6/R7: exception enabled, each single error with rx_full high
        write_en(3'b011);
        for (int k = 0; k < 3; k++) begin
            set_flags(1'b1, 1'b0, 3'(1 << k)); #1;
            check_all("R7 single err");
            chk("R7 rx masked", irq_rx, 1'b0);
        end
        // R6: exception without rx_full
        set_flags(1'b0, 1'b0, 3'b100); #1;
        chk("R6 exc no full", irq_rx_exc, 1'b1);

        // R8/R9: transmit enable, flag falls, request falls same cycle
        write_en(3'b100);
        set_flags(1'b0, 1'b1, 3'b000); #1; chk("R8 tx up", irq_tx, 1'b1);
        set_flags(1'b0, 1'b0, 3'b000); #1; chk("R9 tx falls", irq_tx, 1'b0);

        // R3: soft reset with simultaneous write
        write_en(3'b111);
        @(negedge clk);
        soft_rst = 1'b1; ctl_wr = 1'b1; ctl_wdata = 3'b111;
        @(posedge clk);
        m_en = 3'b000;
        @(negedge clk);
        soft_rst = 1'b0; ctl_wr = 1'b0;
        set_flags(1'b1, 1'b1, 3'b111); #1;
        check_all("R3 soft wins");
        chk("R3 tx cleared", irq_tx, 1'b0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic do_wr, do_soft, do_hw;
            logic [2:0] wv;
            @(negedge clk);
            do_wr   = ($urandom % 4) == 0;
            do_soft = ($urandom % 16) == 0;
            do_hw   = ($urandom % 64) == 0;
            wv      = 3'($urandom);
            ctl_wr = do_wr; ctl_wdata = wv; soft_rst = do_soft; rst = do_hw;
            set_flags(1'($urandom), 1'($urandom), 3'($urandom));
            #1;
            check_all("R9 random");
            @(posedge clk);
            if (do_hw || do_soft) m_en = 3'b000;
            else if (do_wr) m_en = wv;
        end
        @(negedge clk);
        rst = 1'b0; soft_rst = 1'b0; ctl_wr = 1'b0;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule